// File: doc/BRIEF.md
# Leading-edge lockout debouncer

This block turns a bouncing single-bit signal, for example a comparator output that rings after each switching event, into one clean transition per event. It does not wait for the input to go quiet. The first transition that reaches the synchronized side is passed to the output at once. After that a hold-off window starts, and every further transition is ignored until the window closes. One window belongs to rising transitions and one to falling transitions. Only one of them can run at a time, and while either runs the other cannot start.

The block is fully synchronous. The raw input passes through a synchronizer chain and is then compared with the registered clean output. When no window is running and the two differ, the output takes the synchronized level and the window for that direction is loaded. The same rule runs on the cycle a window expires. A level change that was hidden by the lockout and is still present at that point is therefore picked up at once and never lost. The window length is a cycle count, and its default of 50 cycles is 250 ns at 200 MHz. The pins carry no stream, so the block has no valid/ready handshake. The clean output and the busy flag are plain level signals that are valid on every cycle.

Top module: `lockout_debounce`

## Requirements
- R1: While `rst` is high, and on every cycle after it falls until the input changes, `clean_out` is 0 and `busy` is 0.
- R2: With no window running, a 0-to-1 change of `raw_in` that lands between two clock edges makes `clean_out` go to 1 on the third rising clock edge after the change. `busy` rises on that same edge.
- R3: With no window running, a 1-to-0 change of `raw_in` makes `clean_out` go to 0 on the third rising clock edge after the change. `busy` rises on that same edge.
- R4: While `busy` is high, no transition of `raw_in` changes `clean_out`. A burst of bounces that starts with an edge and settles at that edge's new level produces exactly one output transition.
- R5: After a window starts, `busy` stays high for exactly `HOLD_CYCLES` clock cycles.
- R6: The rising window and the falling window are never active together. A transition of the opposite direction during a window neither restarts it nor lengthens it.
- R7: If, when a window ends, the synchronized input differs from `clean_out`, the output takes the input level on the edge after `busy` falls and the matching window starts. If the differing level reaches the synchronizer output one cycle later, the output follows one cycle later.
- R8: `clean_out` is non-inverted. Once the input has settled and no window is running, it equals the settled `raw_in` level.
- R9: An input excursion that starts and ends inside a window leaves no trace. After the window `clean_out` keeps its level and no new window starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| raw_in | input | 1 | Bouncing asynchronous input |
| clean_out | output | 1 | Debounced level, same polarity as the input |
| busy | output | 1 | High while a hold-off window is counting |

## Verification
The case to watch is a window running out on the same cycle that a hidden level change arrives at the synchronizer output. The expiry and the start of the next window then meet on one decision edge. The bench provokes this by timing a level change so that the synchronized sample turns over exactly on the edge where the counter reaches zero. It also tests the sample arriving one cycle later and the sample arriving long before expiry. For each case it expects the output to change on an exact edge, counted from the falling edge of `busy`, and it expects `busy` to rise again on that same edge.

// File: rtl/ldb_pkg.sv
`timescale 1ns/1ps
package ldb_pkg;

  // Window slot indices; the slot a start lands in follows the new level.
  localparam int unsigned WIN_RISE  = 0;
  localparam int unsigned WIN_FALL  = 1;
  localparam int unsigned WIN_COUNT = 2;

  // Default hold-off: 250 ns at a 5 ns clock.
  localparam int unsigned DEF_HOLD_CYCLES = 50;
  localparam int unsigned DEF_SYNC_STAGES = 2;

  // Which window slot a transition to the given level belongs to.
  function automatic int unsigned slot_for_level(input logic lvl);
    return lvl ? WIN_RISE : WIN_FALL;
  endfunction

endpackage

// File: rtl/ldb_sync.sv
`timescale 1ns/1ps
module ldb_sync #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q_sync
);

  logic [STAGES-1:0] chain_q;

  generate
    genvar s;
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[s] <= RESET_VAL;
          else     chain_q[s] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[s] <= RESET_VAL;
          else     chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain_q[STAGES-1];

  initial begin
    a_stage_count: assert (STAGES >= 2)
      else $error("synchronizer needs at least two stages");
  end

endmodule

// File: rtl/ldb_window.sv
`timescale 1ns/1ps
module ldb_window #(
  parameter int unsigned HOLD_CYCLES = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic active
);

  localparam int unsigned CW = $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0] LOAD_VAL = CW'(HOLD_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (load)         cnt_q <= LOAD_VAL;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign active = (cnt_q != '0);

  // R5: a running window counts down by one each cycle
  p_count_down_r5: assert property (@(posedge clk) disable iff (rst)
    (active && !load) |=> (cnt_q == CW'($past(cnt_q) - 1'b1)));

  // R5: a start always reloads the full length
  p_full_load_r5: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt_q == LOAD_VAL));

  // R6: a window is never restarted while it runs
  p_no_restart_r6: assert property (@(posedge clk) disable iff (rst)
    load |-> !active);

endmodule

// File: rtl/ldb_arbiter.sv
`timescale 1ns/1ps
module ldb_arbiter
  import ldb_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 level,
  input  logic [WIN_COUNT-1:0] win_active,
  output logic [WIN_COUNT-1:0] win_start,
  output logic                 out_q
);

  logic locked;
  logic mismatch;
  logic take;

  assign locked   = |win_active;
  assign mismatch = (level != out_q);
  // A fresh edge and a change hidden by an expired window take the same path.
  assign take     = !locked && mismatch;

  always_comb begin
    win_start = '0;
    if (take) win_start[slot_for_level(level)] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)       out_q <= 1'b0;
    else if (take) out_q <= level;
  end

  // R4: the output holds while any window runs
  p_hold_while_locked_r4: assert property (@(posedge clk) disable iff (rst)
    locked |=> $stable(out_q));

  // R7: when unlocked, a differing level is followed on the next edge
  p_follow_when_free_r7: assert property (@(posedge clk) disable iff (rst)
    (!locked && mismatch) |=> (out_q == $past(level)));

  // R8: every output change copies the synchronized level (no inversion)
  p_polarity_r8: assert property (@(posedge clk) disable iff (rst)
    !$stable(out_q) |-> (out_q == $past(level)));

endmodule

// File: rtl/lockout_debounce.sv
`timescale 1ns/1ps
module lockout_debounce
  import ldb_pkg::*;
#(
  parameter int unsigned HOLD_CYCLES = DEF_HOLD_CYCLES,
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_in,
  output logic clean_out,
  output logic busy
);

  logic                 level_sync;
  logic [WIN_COUNT-1:0] win_start;
  logic [WIN_COUNT-1:0] win_active;

  ldb_sync #(
    .STAGES    (SYNC_STAGES),
    .RESET_VAL (1'b0)
  ) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (raw_in),
    .q_sync  (level_sync)
  );

  ldb_arbiter u_arb (
    .clk        (clk),
    .rst        (rst),
    .level      (level_sync),
    .win_active (win_active),
    .win_start  (win_start),
    .out_q      (clean_out)
  );

  generate
    genvar w;
    for (w = 0; w < WIN_COUNT; w++) begin : g_win
      ldb_window #(
        .HOLD_CYCLES (HOLD_CYCLES)
      ) u_win (
        .clk    (clk),
        .rst    (rst),
        .load   (win_start[w]),
        .active (win_active[w])
      );
    end
  endgenerate

  assign busy = |win_active;

  // R6: the two windows never overlap
  p_one_window_r6: assert property (@(posedge clk) disable iff (rst)
    !(win_active[WIN_RISE] && win_active[WIN_FALL]));

  // R2: a rising output is accompanied by the rising window
  p_rise_arms_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(clean_out) |-> (win_active[WIN_RISE] && !win_active[WIN_FALL]));

  // R3: a falling output is accompanied by the falling window
  p_fall_arms_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(clean_out) |-> (win_active[WIN_FALL] && !win_active[WIN_RISE]));

  // R5: busy can only rise together with an output change
  p_busy_needs_edge_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !$stable(clean_out));

  initial begin
    a_hold_nonzero: assert (HOLD_CYCLES >= 1)
      else $error("hold-off length must be at least one cycle");
  end

endmodule

// File: tb/lockout_debounce_test.sv
`timescale 1ns/1ps
module lockout_debounce_test;

  localparam int HOLD = 50;

  logic clk = 1'b0;
  logic rst;
  logic raw_in;
  logic clean_out;
  logic busy;

  int  checks  = 0;
  int  errors  = 0;
  int  toggles = 0;
  logic last_out = 1'b0;
  bit  done = 1'b0;

  always #2.5 clk = ~clk;

  lockout_debounce #(.HOLD_CYCLES(HOLD), .SYNC_STAGES(2)) uut (
    .clk       (clk),
    .rst       (rst),
    .raw_in    (raw_in),
    .clean_out (clean_out),
    .busy      (busy)
  );

  // Count output transitions, sampled away from the active edge.
  always @(negedge clk) begin
    if (!rst && clean_out !== last_out) toggles++;
    last_out = clean_out;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wait_neg(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic settle();
    while (busy) @(negedge clk);
    wait_neg(4);
  endtask

  // R1: reset state and quiet period afterwards
  task automatic t_reset();
    rst = 1'b1;
    raw_in = 1'b0;
    wait_neg(3);
    chk("R1", "clean_out in reset", int'(clean_out), 0);
    chk("R1", "busy in reset", int'(busy), 0);
    rst = 1'b0;
    wait_neg(6);
    chk("R1", "clean_out after reset", int'(clean_out), 0);
    chk("R1", "busy after reset", int'(busy), 0);
  endtask

  // R2/R3 latency and R5 window length for one clean edge
  task automatic t_clean_edge(input logic lvl, input string req);
    int n;
    settle();
    raw_in = lvl;
    wait_neg(1);
    chk(req, "out unchanged after 1 edge", int'(clean_out), int'(!lvl));
    wait_neg(1);
    chk(req, "out unchanged after 2 edges", int'(clean_out), int'(!lvl));
    wait_neg(1);
    chk(req, "out after 3 edges", int'(clean_out), int'(lvl));
    chk(req, "busy with output change", int'(busy), 1);
    n = 0;
    while (busy) begin
      wait_neg(1);
      n++;
    end
    chk("R5", "window length", n, HOLD);
  endtask

  // R4/R8: bounce burst settling at the first edge's level
  task automatic t_burst(input logic lvl);
    settle();
    toggles = 0;
    raw_in = lvl;
    wait_neg(2);
    raw_in = ~raw_in;
    wait_neg(1);
    chk("R2", "burst first-edge latency", int'(clean_out), int'(lvl));
    for (int i = 0; i < 7; i++) begin
      wait_neg(2);
      raw_in = ~raw_in;
    end
    settle();
    chk("R4", "one toggle per burst", toggles, 1);
    chk("R8", "settled polarity", int'(clean_out), int'(lvl));
  endtask

  // R6/R9: opposite excursion inside a window
  task automatic t_opposite_inside();
    int n;
    settle();
    raw_in = 1'b0;
    settle();
    toggles = 0;
    raw_in = 1'b1;
    wait_neg(3);
    chk("R2", "rise before excursion", int'(clean_out), 1);
    n = 0;
    while (busy) begin
      if (n == 5)  raw_in = 1'b0;
      if (n == 15) raw_in = 1'b1;
      wait_neg(1);
      n++;
    end
    chk("R6", "window not extended by opposite edge", n, HOLD);
    wait_neg(3);
    chk("R9", "no new window after excursion", int'(busy), 0);
    chk("R9", "level kept after excursion", int'(clean_out), 1);
    chk("R9", "single toggle", toggles, 1);
  endtask

  // R7: level change hidden by the window; set_at counts cycles into it
  task automatic t_catchup(input int set_at, input int extra);
    int n;
    logic lvl;
    settle();
    lvl = clean_out;
    toggles = 0;
    raw_in = ~lvl;
    wait_neg(3);
    chk("R7", "window started", int'(busy), 1);
    n = 0;
    while (busy) begin
      if (n == set_at) raw_in = lvl;
      wait_neg(1);
      n++;
    end
    chk("R7", "out still held at expiry", int'(clean_out), int'(!lvl));
    if (extra == 2) begin
      wait_neg(1);
      chk("R7", "late sample not yet followed", int'(clean_out), int'(!lvl));
    end
    wait_neg(1);
    chk("R7", "hidden change followed", int'(clean_out), int'(lvl));
    chk("R7", "new window armed", int'(busy), 1);
    settle();
    chk("R7", "two toggles", toggles, 2);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    raw_in = 1'b0;
    t_reset();
    t_clean_edge(1'b1, "R2");
    t_clean_edge(1'b0, "R3");
    t_burst(1'b1);
    t_burst(1'b0);
    t_opposite_inside();
    t_catchup(10, 1);
    t_catchup(HOLD - 2, 1);
    t_catchup(HOLD - 1, 2);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule